// File: doc/BRIEF.md
# Stop-Mode Wake-Up Sequencer

This block governs the deepest standby state of a processor core. When the core issues a stop request, the block records the clock source in use and the chosen stabilization length. It turns off both oscillators and gates the core clock. While stopped, it evaluates a pending interrupt against its mask bit, its priority bit, the global interrupt enable and the in-service priority flag. From these it either keeps the core stopped or wakes it with a decided action: continue at the following instruction, or enter interrupt servicing.

On wake, the oscillator that clocks the core is restarted, and the core clock stays gated for a settling interval. With the crystal as core clock, that interval is a power-of-two count selected by software. With the internal oscillator, it is a fixed, parameterized count. Reset overrides everything at once. It drops the block into a reset-processing interval on the internal oscillator, and the core then restarts with a reset action code. The action code appears for exactly one cycle, the first cycle in which the core clock is enabled again.

Top module: `stop_wake_seq`

## Requirements
- R1: While stopped, an interrupt with `irq_mask`=1, or no pending interrupt at all, leaves the block stopped: `core_clk_en`, `xtal_en` and `irc_en` stay 0 and `wake_act` stays 00, whatever `irq_lowprio`, `irq_en` and `isp_flag` are.
- R2: A pending unmasked interrupt with `irq_lowprio`=0 and `irq_en`=0 wakes the core with action 01 (continue at next instruction).
- R3: A pending unmasked interrupt with `irq_lowprio`=0 and `irq_en`=1 wakes the core with action 10 (interrupt servicing).
- R4: A pending unmasked interrupt with `irq_lowprio`=1 gives action 10 only when `irq_en`=1 and `isp_flag`=1. In the other three combinations it gives action 01.
- R5: `wake_act` is non-zero for exactly one cycle, the first cycle of `core_clk_en`=1 after a wake or reset. It reads 00 in every other cycle.
- R6: A `stop_req` sampled high while running sets `core_clk_en`, `xtal_en` and `irc_en` to 0 from the next cycle on.
- R7: A wake with the crystal selected (`clk_src`=1 at stop entry) holds `xtal_en`=1, `irc_en`=0 and `core_clk_en`=0 for exactly 2^(XTAL_BASE_LOG2+s) cycles, where s = `stab_sel`, and values of XTAL_STEPS or above count as XTAL_STEPS-1.
- R8: A wake with the internal oscillator selected (`clk_src`=0 at stop entry) holds `irc_en`=1, `xtal_en`=0 and `core_clk_en`=0 for exactly IRC_WAIT cycles.
- R9: `clk_src` and `stab_sel` are captured in the cycle the stop request is taken. Changing them while stopped or waiting has no effect on the oscillator chosen or on the wait length.
- R10: Asserting `rst_n` low forces `core_clk_en`=0, `xtal_en`=0, `irc_en`=1 and `wake_act`=00 at once, from any state, without waiting for a clock edge.
- R11: After `rst_n` rises, the core clock stays gated with `irc_en`=1 for SYNC_STAGES+RST_CYCLES-1 cycles. The first enabled cycle carries action 11 (reset).
- R12: While running, `xtal_en` follows `clk_src` and `irc_en` follows its inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on sequencer clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| stop_req | input | 1 | Core requests STOP standby |
| irq_pend | input | 1 | Interrupt request pending |
| irq_mask | input | 1 | Mask bit of the pending request (1 = masked) |
| irq_lowprio | input | 1 | Priority bit of the pending request (1 = low) |
| irq_en | input | 1 | Global interrupt enable |
| isp_flag | input | 1 | In-service priority flag |
| clk_src | input | 1 | Core clock source: 1 = crystal, 0 = internal oscillator |
| stab_sel | input | SEL_W | Crystal stabilization length select |
| xtal_en | output | 1 | Crystal oscillator enable |
| irc_en | output | 1 | Internal oscillator enable |
| core_clk_en | output | 1 | Core clock gate enable |
| wake_act | output | 2 | Wake action: 00 none, 01 next instruction, 10 interrupt, 11 reset |

## Verification
The hardest situations to reach from the ports are the ones that need inputs to change in the middle of a sequence. Two stand out: the selects moving after they have been captured, and reset landing inside a stabilization wait. The bench reaches the first by entering STOP with one source and length, then flipping `clk_src` and `stab_sel` before waking. It then checks that the gated interval and the active oscillator still match the captured values. It reaches the second by dropping `rst_n` partway through a crystal wait and inside plain STOP. It checks the outputs one nanosecond later, and then times the full reset-processing interval. The decision table is swept over all sixteen combinations of the four qualifying bits, and every crystal select value, including the clamped ones, is timed.

// File: rtl/stop_wake_pkg.sv
package stop_wake_pkg;

    typedef enum logic [1:0] {
        ACT_NONE  = 2'b00,
        ACT_NEXT  = 2'b01,
        ACT_ISR   = 2'b10,
        ACT_RESET = 2'b11
    } wake_act_e;

    typedef enum logic [1:0] {
        ST_RUN  = 2'b00,
        ST_STOP = 2'b01,
        ST_STAB = 2'b10,
        ST_RSTP = 2'b11
    } seq_state_e;

endpackage

// File: rtl/swk_rst_sync.sv
module swk_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n_i,
    output logic rst_n_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], 1'b1};
    end

    always_ff @(posedge clk or negedge rst_n_i) begin
        if (!rst_n_i) chain_q <= '0;
        else          chain_q <= chain_d;
    end

    assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/swk_wake_decide.sv
module swk_wake_decide
    import stop_wake_pkg::*;
(
    input  logic      pend_i,
    input  logic      mask_i,
    input  logic      lowprio_i,
    input  logic      ie_i,
    input  logic      isp_i,
    output logic      wake_o,
    output wake_act_e act_o
);
    always_comb begin
        wake_o = pend_i && !mask_i;
        if (!lowprio_i) act_o = ie_i ? ACT_ISR : ACT_NEXT;
        else            act_o = (ie_i && isp_i) ? ACT_ISR : ACT_NEXT;
    end
endmodule

// File: rtl/swk_wait_len.sv
module swk_wait_len #(
    parameter int XTAL_BASE_LOG2 = 11,
    parameter int XTAL_STEPS     = 6,
    parameter int SEL_W          = 3,
    parameter int IRC_WAIT       = 100,
    parameter int CW             = 17
) (
    input  logic             src_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic [CW-1:0]    len_o
);
    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    logic [CW-1:0] step_len [XTAL_STEPS];

    for (genvar g = 0; g < XTAL_STEPS; g++) begin : g_step
        assign step_len[g] = ONE << (XTAL_BASE_LOG2 + g);
    end

    logic [CW-1:0] xtal_len;

    always_comb begin
        xtal_len = step_len[XTAL_STEPS-1];
        for (int k = 0; k < XTAL_STEPS; k++) begin
            if (sel_i == SEL_W'(k)) xtal_len = step_len[k];
        end
        len_o = src_i ? xtal_len : CW'(IRC_WAIT);
    end
endmodule

// File: rtl/stop_wake_seq.sv
module stop_wake_seq
    import stop_wake_pkg::*;
#(
    parameter int XTAL_BASE_LOG2 = 11,
    parameter int XTAL_STEPS     = 6,
    parameter int SEL_W          = 3,
    parameter int IRC_WAIT       = 100,
    parameter int RST_CYCLES     = 16,
    parameter int SYNC_STAGES    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop_req,
    input  logic             irq_pend,
    input  logic             irq_mask,
    input  logic             irq_lowprio,
    input  logic             irq_en,
    input  logic             isp_flag,
    input  logic             clk_src,
    input  logic [SEL_W-1:0] stab_sel,
    output logic             xtal_en,
    output logic             irc_en,
    output logic             core_clk_en,
    output logic [1:0]       wake_act
);
    localparam int XTAL_MAX = 1 << (XTAL_BASE_LOG2 + XTAL_STEPS - 1);
    localparam int M1       = (XTAL_MAX > IRC_WAIT) ? XTAL_MAX : IRC_WAIT;
    localparam int LEN_MAX  = (M1 > RST_CYCLES) ? M1 : RST_CYCLES;
    localparam int CW       = $clog2(LEN_MAX + 1);
    localparam logic [CW-1:0] RST_LAST = CW'(RST_CYCLES - 1);
    localparam logic [CW-1:0] CNT_ONE  = {{(CW-1){1'b0}}, 1'b1};

    typedef struct packed {
        seq_state_e       st;
        logic [CW-1:0]    cnt;
        logic             src;
        logic [SEL_W-1:0] sel;
        wake_act_e        held_act;
        wake_act_e        out_act;
    } seq_reg_t;

    localparam seq_reg_t SEQ_RESET = '{
        st:       ST_RSTP,
        cnt:      '0,
        src:      1'b0,
        sel:      '0,
        held_act: ACT_NONE,
        out_act:  ACT_NONE
    };

    logic          rst_ns;
    logic          wake_hit;
    wake_act_e     wake_kind;
    logic [CW-1:0] wait_len;
    seq_reg_t      seq_d, seq_q;
    seq_state_e    state_q;

    swk_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
        .clk     (clk),
        .rst_n_i (rst_n),
        .rst_n_o (rst_ns)
    );

    swk_wake_decide u_decide (
        .pend_i    (irq_pend),
        .mask_i    (irq_mask),
        .lowprio_i (irq_lowprio),
        .ie_i      (irq_en),
        .isp_i     (isp_flag),
        .wake_o    (wake_hit),
        .act_o     (wake_kind)
    );

    swk_wait_len #(
        .XTAL_BASE_LOG2 (XTAL_BASE_LOG2),
        .XTAL_STEPS     (XTAL_STEPS),
        .SEL_W          (SEL_W),
        .IRC_WAIT       (IRC_WAIT),
        .CW             (CW)
    ) u_wait_len (
        .src_i (seq_q.src),
        .sel_i (seq_q.sel),
        .len_o (wait_len)
    );

    // next-state computation
    always_comb begin
        seq_d         = seq_q;
        seq_d.out_act = ACT_NONE;
        case (seq_q.st)
            ST_RUN: begin
                if (stop_req) begin
                    seq_d.st  = ST_STOP;
                    seq_d.src = clk_src;
                    seq_d.sel = stab_sel;
                    seq_d.cnt = '0;
                end
            end
            ST_STOP: begin
                if (wake_hit) begin
                    seq_d.st       = ST_STAB;
                    seq_d.held_act = wake_kind;
                    seq_d.cnt      = '0;
                end
            end
            ST_STAB: begin
                if (seq_q.cnt == wait_len - CNT_ONE) begin
                    seq_d.st      = ST_RUN;
                    seq_d.out_act = seq_q.held_act;
                    seq_d.cnt     = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + CNT_ONE;
                end
            end
            default: begin
                if (seq_q.cnt == RST_LAST) begin
                    seq_d.st      = ST_RUN;
                    seq_d.out_act = ACT_RESET;
                    seq_d.cnt     = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + CNT_ONE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_ns) begin
        if (!rst_ns) seq_q <= SEQ_RESET;
        else         seq_q <= seq_d;
    end

    assign state_q = seq_q.st;

    always_comb begin
        core_clk_en = (seq_q.st == ST_RUN);
        wake_act    = seq_q.out_act;
        case (seq_q.st)
            ST_RUN:  begin xtal_en = clk_src;    irc_en = !clk_src;    end
            ST_STAB: begin xtal_en = seq_q.src;  irc_en = !seq_q.src;  end
            ST_RSTP: begin xtal_en = 1'b0;       irc_en = 1'b1;        end
            default: begin xtal_en = 1'b0;       irc_en = 1'b0;        end
        endcase
    end

    // R1: a masked request never leaves STOP
    assert_masked_hold_R1: assert property (@(posedge clk) disable iff (!rst_ns)
        (state_q == ST_STOP && irq_mask) |=> (state_q == ST_STOP));

    // R5: action code lasts one cycle
    assert_act_pulse_R5: assert property (@(posedge clk) disable iff (!rst_ns)
        (wake_act != 2'b00) |=> (wake_act == 2'b00));

    // R5: action code only on the first enabled cycle
    assert_act_on_enable_R5: assert property (@(posedge clk) disable iff (!rst_ns)
        (wake_act != 2'b00) |-> (core_clk_en && !$past(core_clk_en)));

    // R6: stop request shuts everything off next cycle
    assert_stop_quiet_R6: assert property (@(posedge clk) disable iff (!rst_ns)
        (state_q == ST_RUN && stop_req) |=> (!core_clk_en && !xtal_en && !irc_en));

    // R9: captured selects do not move outside the running state
    assert_sel_stable_R9: assert property (@(posedge clk) disable iff (!rst_ns)
        (state_q != ST_RUN && $past(state_q) != ST_RUN) |-> ($stable(seq_q.sel) && $stable(seq_q.src)));

    // R11: leaving reset processing always reports the reset action
    assert_reset_act_R11: assert property (@(posedge clk) disable iff (!rst_ns)
        (state_q == ST_RUN && $past(state_q) == ST_RSTP) |-> (wake_act == 2'b11));

endmodule

// File: tb/tb_stop_wake_seq.sv
`timescale 1ns/1ps
module tb_stop_wake_seq;
    localparam int BASE  = 3;
    localparam int STEPS = 6;
    localparam int SELW  = 3;
    localparam int IRCW  = 20;
    localparam int RSTC  = 5;
    localparam int SYNC  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stop_req = 0, irq_pend = 0, irq_mask = 0, irq_lowprio = 0;
    logic irq_en = 0, isp_flag = 0, clk_src = 0;
    logic [SELW-1:0] stab_sel = '0;
    logic xtal_en, irc_en, core_clk_en;
    logic [1:0] wake_act;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    stop_wake_seq #(
        .XTAL_BASE_LOG2 (BASE), .XTAL_STEPS (STEPS), .SEL_W (SELW),
        .IRC_WAIT (IRCW), .RST_CYCLES (RSTC), .SYNC_STAGES (SYNC)
    ) dut (
        .clk, .rst_n, .stop_req, .irq_pend, .irq_mask, .irq_lowprio,
        .irq_en, .isp_flag, .clk_src, .stab_sel,
        .xtal_en, .irc_en, .core_clk_en, .wake_act
    );

    task automatic check(string req, int actual, int expected);
        n_cmp++;
        if (actual != expected) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    function automatic int exp_act(bit lowp, bit ie, bit isp);
        if (!lowp) return ie ? 2 : 1;
        return (ie && isp) ? 2 : 1;
    endfunction

    function automatic int xtal_len(int sel);
        int s = (sel >= STEPS) ? STEPS - 1 : sel;
        return 1 << (BASE + s);
    endfunction

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic enter_stop(bit src, int sel);
        @(negedge clk);
        clk_src = src; stab_sel = SELW'(sel); stop_req = 1;
        @(negedge clk);
        stop_req = 0;
        check("R6 core gated after stop", core_clk_en, 0);
        check("R6 oscillators off after stop", xtal_en | irc_en, 0);
    endtask

    task automatic wake_measure(bit lowp, bit ie, bit isp, bit src,
                                int exp_len, int exp_a, string tag);
        int  n = 0;
        bit  osc_ok = 1;
        irq_mask = 0; irq_lowprio = lowp; irq_en = ie; isp_flag = isp; irq_pend = 1;
        @(negedge clk);
        irq_pend = 0;
        while (!core_clk_en) begin
            n++;
            if (xtal_en !== src || irc_en !== !src) osc_ok = 0;
            @(negedge clk);
        end
        check(src ? "R7 crystal wait length" : "R8 internal wait length", n, exp_len);
        check(src ? "R7 crystal enable during wait" : "R8 internal enable during wait",
              int'(osc_ok), 1);
        check(tag, int'(wake_act), exp_a);
        @(negedge clk);
        check("R5 action cleared after one cycle", int'(wake_act), 0);
    endtask

    task automatic reset_release();
        int n = 0;
        bit irc_ok = 1;
        rst_n = 1;
        @(negedge clk);
        while (!core_clk_en) begin
            n++;
            if (!irc_en || xtal_en) irc_ok = 0;
            @(negedge clk);
        end
        check("R11 reset processing length", n, SYNC + RSTC - 1);
        check("R11 internal oscillator during reset processing", int'(irc_ok), 1);
        check("R11 reset action code", int'(wake_act), 3);
        @(negedge clk);
        check("R5 reset action cleared", int'(wake_act), 0);
    endtask

    task automatic check_reset_outputs(string where);
        check({"R10 core off ", where}, core_clk_en, 0);
        check({"R10 crystal off ", where}, xtal_en, 0);
        check({"R10 internal on ", where}, irc_en, 1);
        check({"R10 action none ", where}, int'(wake_act), 0);
    endtask

    initial begin
        #12;
        check_reset_outputs("at power-up");
        @(negedge clk);
        reset_release();

        // R12: oscillator pass-through while running
        @(negedge clk);
        clk_src = 1; #1;
        check("R12 crystal follows select", xtal_en, 1);
        check("R12 internal follows select", irc_en, 0);
        clk_src = 0; #1;
        check("R12 crystal follows select low", xtal_en, 0);
        check("R12 internal follows select low", irc_en, 1);

        // decision table sweep: R1 R2 R3 R4
        for (int m = 0; m < 16; m++) begin
            bit msk = m[3], lp = m[2], ie = m[1], isp = m[0];
            enter_stop(0, 0);
            if (msk) begin
                bit held_ok = 1;
                irq_mask = 1; irq_lowprio = lp; irq_en = ie; isp_flag = isp; irq_pend = 1;
                for (int k = 0; k < 8; k++) begin
                    @(negedge clk);
                    if (core_clk_en || xtal_en || irc_en || wake_act != 2'b00) held_ok = 0;
                end
                check("R1 masked request keeps STOP", int'(held_ok), 1);
                irq_pend = 0;
                wake_measure(0, 0, 0, 0, IRCW, 1, "R2 exit after masked hold");
            end else begin
                wake_measure(lp, ie, isp, 0, IRCW, exp_act(lp, ie, isp),
                             lp ? "R4 low-priority action" : (ie ? "R3 enabled action" : "R2 disabled action"));
            end
        end

        // R1: no pending request holds too
        begin
            bit idle_ok = 1;
            enter_stop(0, 0);
            irq_mask = 0; irq_pend = 0; irq_en = 1;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                if (core_clk_en || xtal_en || irc_en) idle_ok = 0;
            end
            check("R1 no request keeps STOP", int'(idle_ok), 1);
            wake_measure(0, 1, 0, 0, IRCW, 2, "R3 action after idle stop");
        end

        // R7: every crystal select, including clamped values
        for (int s = 0; s < 8; s++) begin
            enter_stop(1, s);
            wake_measure(0, 1, 0, 1, xtal_len(s), 2, "R3 action on crystal wake");
        end

        // R9: changes during STOP are ignored
        enter_stop(1, 2);
        clk_src = 0; stab_sel = 3'd7;
        @(negedge clk);
        wake_measure(1, 0, 1, 1, xtal_len(2), 1, "R9 captured selects, R4 action");
        clk_src = 0;

        // R10: reset in the middle of a crystal wait
        enter_stop(1, 5);
        irq_mask = 0; irq_lowprio = 0; irq_en = 1; irq_pend = 1;
        repeat (4) @(negedge clk);
        irq_pend = 0;
        #1 rst_n = 0;
        #1 check_reset_outputs("during wait");
        @(negedge clk);
        reset_release();

        // R10: reset while stopped
        enter_stop(0, 0);
        #1 rst_n = 0;
        #1 check_reset_outputs("during STOP");
        @(negedge clk);
        reset_release();

        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end
endmodule